// File: doc/BRIEF.md
# Cycle and Fairness Arbitration Timer

This block times the idle gaps on a shared serial bus for one node and decides when that node may join arbitration. It tracks how long the bus has been idle and compares that count with three gap lengths: a short isochronous gap, a longer subaction gap, and the longest gap, the arbitration reset gap. From these comparisons it raises permission flags for the isochronous phase and for the asynchronous phase. All times are counted in ticks of a slow enable input, so the gap lengths and the cycle length are parameters in ticks.

When cycle-master duty is enabled, the block also keeps the nominal cycle period and asks for a cycle start once per period. If the bus is busy when a start falls due, the start waits until the bus goes idle. The number of ticks it waited is reported with the start pulse. A fairness rule limits asynchronous traffic. Once the node wins an asynchronous arbitration, it loses its asynchronous permission. It gets that permission back only after the bus has been idle for the full arbitration reset gap. An isochronous channel is granted at most once per cycle.

Top module: `cyc_fair_timer`

## Requirements
- R1: With `cm_en` high and the bus idle, `cyc_start` pulses for one clock every `CYCLE_TICKS` ticks. The pulse comes on the clock after the tick that completes the period.
- R2: `iso_ok` is high only when all of these hold: an isochronous window is open (it opens the clock after a `cyc_start` pulse and closes once the idle count reaches `SUB_GAP`), `iso_req` is high, `bus_idle` is high, and the idle count is at least `ISO_GAP`.
- R3: `async_ok` is high only when `async_req` and `bus_idle` are high, the idle count is at least `SUB_GAP`, and the fairness enable is set.
- R4: A clock in which `won` and `async_ok` are both high clears the fairness enable. `async_ok` then stays low whatever `async_req` does, until the enable is restored.
- R5: The fairness enable is set again when the idle count reaches `RST_GAP`. Clearing (R4) has priority in the same clock.
- R6: If a start falls due while the bus is busy, it is held. `cyc_start` pulses on the clock after `bus_idle` is next high. `cyc_delay` then holds the number of ticks that arrived while the start was held, saturating at its maximum, and keeps that value until the next pulse.
- R7: A clock in which `won` and `iso_ok` are both high marks the isochronous request as served. After that, `iso_req` is ignored until the clock after the next `cyc_start` pulse.
- R8: The idle count goes to zero on any clock with `bus_idle` low. It increases by one on each tick while the bus is idle and stops at `RST_GAP`.
- R9: With `cm_en` low, the period counter and any held start are cleared, and `cyc_start` stays low.
- R10: After reset, `iso_ok`, `async_ok`, `cyc_start` and `cyc_delay` are zero and the fairness enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable; all gaps and periods count these |
| bus_idle | input | 1 | High while the bus carries no traffic |
| cm_en | input | 1 | Enables cycle-master timing |
| iso_req | input | 1 | Node wants an isochronous slot |
| async_req | input | 1 | Node wants an asynchronous slot |
| won | input | 1 | Node won the arbitration it is permitted for |
| iso_ok | output | 1 | Isochronous arbitration permitted |
| async_ok | output | 1 | Asynchronous arbitration permitted |
| cyc_start | output | 1 | One-clock request to send a cycle start |
| cyc_delay | output | $clog2(CYCLE_TICKS+1) | Ticks by which the last cycle start was held |

## Verification
Some rules are checked on every clock. The start pulse lasts exactly one clock and never appears when cycle-master duty is off. Neither permission flag is raised unless the bus was idle on the previous clock. An asynchronous win removes asynchronous permission on the next clock, and an isochronous win removes isochronous permission on the next clock. Other behaviour can only be shown by scenarios, because the expected values build up over hundreds of ticks. This includes the exact spacing of cycle starts, the reported delay value, restoring permission after the reset gap, and reopening the isochronous window in the next cycle. A reference model in the bench tracks these, while random stretches of bus traffic push starts past their due time.

// File: rtl/cyc_fair_timer.sv
module cyc_fair_timer #(
  parameter int CYCLE_TICKS = 100,
  parameter int ISO_GAP     = 2,
  parameter int SUB_GAP     = 10,
  parameter int RST_GAP     = 20
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick,
  input  logic                               bus_idle,
  input  logic                               cm_en,
  input  logic                               iso_req,
  input  logic                               async_req,
  input  logic                               won,
  output logic                               iso_ok,
  output logic                               async_ok,
  output logic                               cyc_start,
  output logic [$clog2(CYCLE_TICKS+1)-1:0]   cyc_delay
);
  localparam int IW = $clog2(RST_GAP + 1);
  localparam int CW = $clog2(CYCLE_TICKS);
  localparam int DW = $clog2(CYCLE_TICKS + 1);
  localparam logic [IW-1:0] ISO_T  = IW'(ISO_GAP);
  localparam logic [IW-1:0] SUB_T  = IW'(SUB_GAP);
  localparam logic [IW-1:0] RST_T  = IW'(RST_GAP);
  localparam logic [CW-1:0] LAST_C = CW'(CYCLE_TICKS - 1);
  localparam logic [DW-1:0] DLY_MAX = '1;

  logic [IW-1:0] idle_cnt;
  logic [CW-1:0] cyc_cnt;
  logic [DW-1:0] dly_cnt;
  logic          arb_en, iso_open, iso_done, pend;

  wire due = cm_en && tick && (cyc_cnt == LAST_C);

  assign iso_ok   = iso_open && !iso_done && iso_req && bus_idle && (idle_cnt >= ISO_T);
  assign async_ok = arb_en && async_req && bus_idle && (idle_cnt >= SUB_T);

  always_ff @(posedge clk) begin
    if (!rst_n) idle_cnt <= '0;
    else if (!bus_idle) idle_cnt <= '0;
    else if (tick && idle_cnt < RST_T) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) arb_en <= 1'b1;
    else if (won && async_ok) arb_en <= 1'b0;
    else if (idle_cnt == RST_T) arb_en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_open <= 1'b0;
      iso_done <= 1'b0;
    end else if (cyc_start) begin
      iso_open <= 1'b1;
      iso_done <= 1'b0;
    end else begin
      if (idle_cnt >= SUB_T) iso_open <= 1'b0;
      if (won && iso_ok) iso_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_cnt   <= '0;
      dly_cnt   <= '0;
      pend      <= 1'b0;
      cyc_start <= 1'b0;
      cyc_delay <= '0;
    end else begin
      cyc_start <= 1'b0;
      if (!cm_en) cyc_cnt <= '0;
      else if (tick) cyc_cnt <= (cyc_cnt == LAST_C) ? '0 : cyc_cnt + 1'b1;
      if (!cm_en) begin
        pend <= 1'b0;
      end else if (due) begin
        pend    <= 1'b1;
        dly_cnt <= '0;
      end else if (pend && bus_idle) begin
        pend      <= 1'b0;
        cyc_start <= 1'b1;
        cyc_delay <= dly_cnt;
      end else if (pend && tick && dly_cnt != DLY_MAX) begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end
endmodule

module cyc_fair_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cm_en,
  input logic bus_idle,
  input logic won,
  input logic iso_ok,
  input logic async_ok,
  input logic cyc_start
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cyc_start |=> !cyc_start); // R1
  AST_START_NEEDS_CM: assert property (@(posedge clk) disable iff (!rst_n) cyc_start |-> $past(cm_en)); // R9
  AST_ASYNC_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) async_ok |-> $past(bus_idle)); // R3
  AST_ISO_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) iso_ok |-> $past(bus_idle)); // R2
  AST_FAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (won && async_ok) |=> !async_ok); // R4
  AST_ISO_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (won && iso_ok && !cyc_start) |=> !iso_ok); // R7
endmodule

bind cyc_fair_timer cyc_fair_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cm_en(cm_en), .bus_idle(bus_idle), .won(won),
  .iso_ok(iso_ok), .async_ok(async_ok), .cyc_start(cyc_start)
);

// File: tb/tb_cyc_fair_timer.sv
module tb_cyc_fair_timer;
  localparam int CT = 100, IG = 2, SG = 10, RG = 20;
  localparam int DW = $clog2(CT + 1);

  logic clk = 0, rst_n = 0, tick = 0, bus_idle = 1, cm_en = 1;
  logic iso_req = 0, async_req = 0, won = 0;
  logic iso_ok, async_ok, cyc_start;
  logic [DW-1:0] cyc_delay;
  int checks = 0, fails = 0, busy_left = 0;

  always #2 clk = ~clk;

  cyc_fair_timer #(.CYCLE_TICKS(CT), .ISO_GAP(IG), .SUB_GAP(SG), .RST_GAP(RG)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_idle(bus_idle), .cm_en(cm_en),
    .iso_req(iso_req), .async_req(async_req), .won(won), .iso_ok(iso_ok),
    .async_ok(async_ok), .cyc_start(cyc_start), .cyc_delay(cyc_delay));

  int m_idle, m_cnt, m_dly, m_delay;
  bit m_en, m_open, m_done, m_pend, m_start;

  function automatic bit exp_iso();
    return m_open && !m_done && iso_req && bus_idle && m_idle >= IG;
  endfunction
  function automatic bit exp_async();
    return m_en && async_req && bus_idle && m_idle >= SG;
  endfunction

  always @(posedge clk) begin
    bit ei, ea;
    ei = exp_iso();
    ea = exp_async();
    if (!rst_n) begin
      m_idle = 0; m_en = 1; m_open = 0; m_done = 0;
      m_cnt = 0; m_dly = 0; m_pend = 0; m_start = 0; m_delay = 0;
    end else begin
      if (won && ea) m_en = 0;
      else if (m_idle == RG) m_en = 1;
      if (m_start) begin m_open = 1; m_done = 0; end
      else begin
        if (m_idle >= SG) m_open = 0;
        if (won && ei) m_done = 1;
      end
      m_start = 0;
      if (!cm_en) m_pend = 0;
      else if (tick && m_cnt == CT - 1) begin m_pend = 1; m_dly = 0; end
      else if (m_pend && bus_idle) begin m_pend = 0; m_start = 1; m_delay = m_dly; end
      else if (m_pend && tick && m_dly < (1 << DW) - 1) m_dly++;
      if (!cm_en) m_cnt = 0;
      else if (tick) m_cnt = (m_cnt == CT - 1) ? 0 : m_cnt + 1;
      if (!bus_idle) m_idle = 0;
      else if (tick && m_idle < RG) m_idle++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R7 iso_ok", iso_ok, exp_iso());
    chk("R3/R4/R5/R8 async_ok", async_ok, exp_async());
    chk("R1/R9 cyc_start", cyc_start, m_start);
    chk("R6 cyc_delay", cyc_delay, m_delay);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1394_5a5a));
    repeat (3) @(negedge clk);
    async_req = 1; iso_req = 1;
    #1;
    chk("R10 iso_ok reset", iso_ok, 0);
    chk("R10 async_ok reset", async_ok, 0);
    chk("R10 cyc_start reset", cyc_start, 0);
    chk("R10 cyc_delay reset", cyc_delay, 0);
    @(negedge clk); rst_n = 1;
    // R8/R5 directed: idle long enough, async permitted, then win clears (R4)
    tick = 1;
    repeat (SG + 1) @(negedge clk);
    #1 chk("R3 async_ok after subaction gap", async_ok, 1);
    won = 1;
    @(negedge clk); won = 0;
    #1 chk("R4 async_ok after win", async_ok, 0);
    repeat (RG + 2) @(negedge clk);
    #1 chk("R5 async_ok after reset gap", async_ok, 1);
    bus_idle = 0;
    @(negedge clk); bus_idle = 1;
    #1 chk("R8 async_ok after busy clock", async_ok, 0);
    // R6 directed: hold bus busy across the due point
    while (m_cnt != CT - 5) @(negedge clk);
    bus_idle = 0;
    repeat (12) @(negedge clk);
    bus_idle = 1;
    @(negedge clk); #1
    chk("R6 delayed start pulse", cyc_start, 1);
    chk("R6 delay value", cyc_delay, 7);
    // random phase
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      tick = ($urandom % 2) == 0;
      if (i == 20000) cm_en = 0;
      if (i == 20600) cm_en = 1;
      if (busy_left > 0) begin busy_left--; bus_idle = 0; end
      else if ($urandom % 40 == 0) begin busy_left = $urandom % 60; bus_idle = 0; end
      else bus_idle = 1;
      iso_req = ($urandom % 4) != 0;
      async_req = ($urandom % 3) != 0;
      won = (exp_iso() || exp_async()) && ($urandom % 2 == 0);
      #1 compare_all();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule